// File: doc/BRIEF.md
# Four-Word Burst Split-Port SRAM Model

This block is a small synthesizable memory with two independent data paths: a write-only data input and a read-only data output. Because the two directions never share a data bus, no bus turnaround cycle is ever needed. Both paths draw their address from one shared address bus. The block alternates its clock cycles between a read slot and a write slot, and the address on the bus is taken as a read address or a write address depending on the slot.

Every address selects a group of four words. A burst moves the four words of a group in ascending order, word 0 first, with no wrap offset. Two words move per clock period, one after the rising edge and one after the falling edge, so a burst takes two cycles on each path. Each path has its own active-low select. A write burst goes into the array only after all four words have arrived. A read that follows a write to the same group is still served with the newest data. The block is intended as a behavioural stand-in for a burst-oriented, double-data-rate memory. Its read latency is fixed, and a data-valid flag marks every burst.

Top module: `quad_burst_sram`

## Requirements
- R1: After reset is released, the first rising edge is a read slot and the slots then alternate (read, write, read, ...). A read select seen in a write slot, or a write select seen in a read slot, is ignored.
- R2: For a read accepted at rising edge n, word 0 of the group appears on `dout` after the falling edge of cycle n+1, word 1 after rising edge n+2, word 2 after the falling edge of cycle n+2 and word 3 after rising edge n+3. Word k is bits [k*W +: W] of the group.
- R3: `dout_vld` rises at the falling edge of cycle n+1 and stays high for exactly two clock periods for each accepted read. It is low whenever no burst is being driven.
- R4: For a write accepted at rising edge n, word 0 is sampled at that edge, word 1 at the falling edge of cycle n, word 2 at rising edge n+1 and word 3 at the falling edge of cycle n+1.
- R5: A read issued in the slot right after a write to the same group returns the four words of that write, even though the write has not yet reached the array. A read issued before a write returns the older contents.
- R6: While no read burst is active, `dout_vld` stays low and `dout` holds the last word driven, on both clock phases.
- R7: A write slot with `wr_sel_n` high leaves the addressed group unchanged, whatever is on `din`.
- R8: Reads accepted in consecutive read slots produce gapless bursts, with `dout_vld` held high across them.
- R9: During reset, `dout` is zero and `dout_vld` is low.
- R10: A read and a write to different groups in neighbouring slots do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Both edges carry data. Inputs are registered on it. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| addr | input | AW | Group address. Taken as the read address in read slots and as the write address in write slots. |
| rd_sel_n | input | 1 | Active-low read select, sampled in read slots. |
| wr_sel_n | input | 1 | Active-low write select, sampled in write slots. |
| din | input | W | Write data, sampled on both edges during a write burst. |
| dout | output | W | Read data, updated on both edges during a read burst. |
| dout_vld | output | 1 | High while a read burst is on `dout`. |

## Verification
The assertions assume that the driver keeps in step with the slot alternation that begins at reset release. They also assume that `din` is stable around both edges of every write cycle and that every group is written before it is first read, since the array itself has no reset value. The stimulus releases reset just after a rising edge, so the next edge is the first read slot, and from then on it always issues inputs as read-slot/write-slot pairs. All inputs change 1 ns after an edge. The bench fills every group before any read. Selects placed deliberately in the wrong slot are used only to show that they are ignored.

// File: rtl/quad_burst_sram.sv
`timescale 1ns/1ps
module quad_burst_sram #(
  parameter int W = 18,
  parameter int GROUPS = 64,
  localparam int AW = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          dout_vld
);
  localparam int GW = 4 * W;

  logic          slot_wr;
  logic          rd_pend, rburst, rsecond;
  logic [AW-1:0] ra_q;
  logic          wst1, wst2;
  logic [AW-1:0] wa1, wa2;
  logic [W-1:0]  w0, w1, w2, din_n;
  logic [GW-1:0] mem [GROUPS];
  logic [GW-1:0] rbuf;
  logic [W-1:0]  dout_r, dout_f;
  logic          vld_f;

  wire [GW-1:0] wgroup = {din_n, w2, w1, w0};
  wire          fwd    = wst2 && (wa2 == ra_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_wr <= 1'b0;
      rd_pend <= 1'b0;
      wst1    <= 1'b0;
      wst2    <= 1'b0;
      rburst  <= 1'b0;
      rsecond <= 1'b0;
      dout_r  <= '0;
    end else begin
      slot_wr <= ~slot_wr;
      rd_pend <= !slot_wr && !rd_sel_n;
      wst1    <= slot_wr && !wr_sel_n;
      wst2    <= wst1;
      if (rd_pend) begin
        rburst  <= 1'b1;
        rsecond <= 1'b0;
      end else if (rburst) begin
        rsecond <= ~rsecond;
        if (rsecond) rburst <= 1'b0;
      end
      if (rburst) dout_r <= rsecond ? rbuf[3*W +: W] : rbuf[W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!slot_wr) ra_q <= addr;
    if (slot_wr) begin
      wa1 <= addr;
      w0  <= din;
    end
    if (wst1) begin
      wa2 <= wa1;
      w1  <= din_n;
      w2  <= din;
    end
    if (wst2) mem[wa2] <= wgroup;
    if (rd_pend) rbuf <= fwd ? wgroup : mem[ra_q];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_n  <= '0;
      dout_f <= '0;
      vld_f  <= 1'b0;
    end else begin
      din_n  <= din;
      vld_f  <= rburst;
      dout_f <= rburst ? (rsecond ? rbuf[2*W +: W] : rbuf[0 +: W]) : dout_r;
    end
  end

  assign dout     = clk ? dout_r : dout_f;
  assign dout_vld = vld_f;

  a_r1_slots_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pend && wst1));
  a_r7_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    wst1 |-> $past(!wr_sel_n));
  a_r2_fetch_starts_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> (rburst && !rsecond));
  a_r3_burst_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (rburst && !rsecond) |=> (rburst && rsecond));
  a_r3_vld_tracks_burst: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld == rburst);
  a_r6_idle_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!rburst && !$past(rburst)) |-> (dout_r == dout_f));
endmodule

// File: tb/sim_quad_burst_sram.sv
`timescale 1ns/1ps
module sim_quad_burst_sram;
  localparam int W = 18;
  localparam int GROUPS = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd_sel_n = 1'b1;
  logic wr_sel_n = 1'b1;
  logic [W-1:0] din = '0;
  wire  [W-1:0] dout;
  wire          dout_vld;

  quad_burst_sram #(.W(W), .GROUPS(GROUPS)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string tag = "R9";
  logic [W-1:0] refm [GROUPS][4];
  bit ev [int];
  logic [W-1:0] ed [int];
  logic [W-1:0] last_d = '0;
  logic [W-1:0] p2 = '0;
  logic [W-1:0] p3 = '0;

  function automatic logic [4*W-1:0] pat(int a, int s);
    logic [4*W-1:0] g;
    for (int k = 0; k < 4; k++) g[k*W +: W] = W'(a * 37 + k * 11 + s * 101 + a * s * 3 + 5);
    return g;
  endfunction

  task automatic sample(int h);
    bit e_v;
    logic [W-1:0] e_d;
    e_v = ev.exists(h);
    e_d = e_v ? ed[h] : last_d;
    last_d = e_d;
    checks++;
    if (dout_vld !== e_v || dout !== e_d) begin
      errors++;
      $display("FAIL %s (R2 R3 output) half %0d: actual vld=%b data=%h expected vld=%b data=%h",
               tag, h, dout_vld, dout, e_v, e_d);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        cyc++;
        #1 sample(2 * (cyc - 1));
        @(negedge clk);
        #1 sample(2 * (cyc - 1) + 1);
      end
    end
  end

  task automatic pair(bit rd, int ra, bit wr, int wa, logic [4*W-1:0] dg, bit stray);
    int n;
    @(negedge clk); #1;
    addr = AW'(ra); rd_sel_n = !rd; wr_sel_n = !stray; din = p2;
    @(posedge clk); #1;
    din = p3;
    n = cyc - 1;
    if (rd) for (int k = 0; k < 4; k++) begin
      ev[2 * n + 3 + k] = 1'b1;
      ed[2 * n + 3 + k] = refm[ra][k];
    end
    @(negedge clk); #1;
    addr = AW'(wa); rd_sel_n = !stray; wr_sel_n = !wr; din = dg[0 +: W];
    @(posedge clk); #1;
    din = dg[W +: W];
    p2 = dg[2*W +: W];
    p3 = dg[3*W +: W];
    if (wr) for (int k = 0; k < 4; k++) refm[wa][k] = dg[k*W +: W];
  endtask

  task automatic idle(int count);
    for (int i = 0; i < count; i++) pair(1'b0, 0, 1'b0, 0, pat(i, 77), 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dout !== '0) begin
      errors++;
      $display("FAIL R9 reset dout: actual=%h expected=0", dout);
    end
    checks++;
    if (dout_vld !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset vld: actual=%b expected=0", dout_vld);
    end
    rst_n = 1'b1;

    tag = "R4";
    for (int a = 0; a < GROUPS; a++) pair(1'b0, 0, 1'b1, a, pat(a, 1), 1'b0);

    tag = "R8";
    for (int a = 0; a < 10; a++) pair(1'b1, a, 1'b0, 0, pat(a, 9), 1'b0);

    tag = "R10";
    for (int i = 0; i < 8; i++) pair(1'b1, i, 1'b1, 40 + i, pat(i, 2), 1'b0);
    for (int i = 0; i < 4; i++) pair(1'b1, 40 + i, 1'b0, 0, '0, 1'b0);

    tag = "R5";
    for (int i = 0; i < 3; i++) begin
      pair(1'b0, 0, 1'b1, 20 + i, pat(20 + i, 3 + i), 1'b0);
      pair(1'b1, 20 + i, 1'b0, 0, '0, 1'b0);
    end
    pair(1'b1, 25, 1'b1, 25, pat(25, 7), 1'b0);
    pair(1'b1, 25, 1'b1, 25, pat(25, 8), 1'b0);
    pair(1'b1, 25, 1'b0, 0, '0, 1'b0);

    tag = "R6";
    pair(1'b1, 5, 1'b0, 0, pat(5, 31), 1'b0);
    idle(4);

    tag = "R7";
    pair(1'b0, 0, 1'b0, 12, pat(12, 99), 1'b0);
    pair(1'b1, 12, 1'b0, 0, '0, 1'b0);
    idle(2);

    tag = "R1";
    pair(1'b0, 13, 1'b0, 13, pat(13, 55), 1'b1);
    idle(3);
    pair(1'b1, 13, 1'b0, 0, '0, 1'b0);
    idle(4);

    finish_run();
  end
endmodule